// File: doc/BRIEF.md
# Parallel 3x3 Sliding-Window Stream Generator

This block is the streaming front end for 3x3 neighbourhood operations such as morphology, median or edge filters. Pixels arrive in raster order, `P` pixels of `DW` bits per accepted transfer. The block keeps whole image rows in internal line queues, so the frame passes through without ever being stored in full. Each time a pixel block is taken in, the block produces `P` overlapping 3x3 windows. Each window has a flag that marks a centre on the image border.

The block is built as a line-queue datapath plus a small row/column controller. Every queue moves a whole `P`-pixel block per step, so its read and write ports are `P*DW` bits wide. Across the whole window, a carry register for each window row keeps the rightmost pixel of the previous block. The leftmost window of the next block gets its left neighbour from that register. A pass-through processing element returns the centre pixel of each window, which lets the window path be observed without any arithmetic.

Two border treatments are chosen by parameter:
- **Constant fill:** every neighbour outside the image takes the value `FILL`.
- **Horizontal torus:** left and right neighbours wrap to the opposite column of the same row, while rows above and below the image still take `FILL`. The wrap needs all three window rows in full before the left edge of a row can be built. This mode therefore uses one more line queue and one more row of latency.

Top module: `par_window_gen`

## Requirements
- R1: For each output block, window `j` (0..P-1) is centred on image column `blk*P+j` of the reported row. Element `r*3+c` of the window is the pixel at row offset `r-1` and column offset `c-1`. It sits at `outWin[(j*9+r*3+c)*DW +: DW]`. Input pixel `j` of a block is column `blk*P+j` and sits at `inPix[j*DW +: DW]`.
- R2: Output blocks come in raster order of their centres, one row at a time and left to right. Exactly `HEIGHT*WIDTH/P` output blocks are produced per frame. Each output block appears with `outValid` high for one cycle. `outValid` is low out of reset.
- R3: With a continuous input stream, the first `outValid` of a frame follows the clock edge that accepts the first input block by `LAG*WIDTH/P+1` edges. `LAG` is 1 in constant mode and 2 in torus mode.
- R4: In constant mode (`WRAP_MODE=0`), every window element whose row or column lies outside the image equals `FILL`.
- R5: In torus mode (`WRAP_MODE=1`), a column of -1 reads column `WIDTH-1` of the same row, and a column of `WIDTH` reads column 0. A row outside the image reads `FILL`.
- R6: `outBorder[j]` is high exactly when the centre of window `j` lies in row 0, row `HEIGHT-1`, column 0 or column `WIDTH-1`.
- R7: A cycle with `inValid` low while `inReady` is high changes no state. No output block follows that clock edge.
- R8: After the last block of a frame is accepted, `inReady` stays low for exactly `LAG*WIDTH/P+1` cycles. During that time the final rows are flushed out. The next frame is then accepted normally.
- R9: `outPix[j*DW +: DW]` equals the centre element of window `j` of the same output block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input pixel block present |
| inReady | output | 1 | Block can accept input (low while flushing) |
| inPix | input | P*DW | Input pixel block, pixel j at bits j*DW |
| outValid | output | 1 | Output block present this cycle |
| outWin | output | P*9*DW | P windows of nine pixels |
| outBorder | output | P | Border flag for each window centre |
| outPix | output | P*DW | Pass-through element result (window centre) |

## Verification
Two instances run side by side, one in constant mode with four pixels per block and one in torus mode with two pixels per block. Both are fed frames of distinct, position-coded pixels, so a window taken from the wrong row, the wrong column or the wrong frame shows up as a wrong value. The first frame is streamed with no gaps, which pins the fill latency and the length of the flush. The second frame has idle cycles inserted before selected blocks; this separates a design that stalls cleanly from one that advances its counters or emits blocks on idle cycles. The corners, the first and last columns and the first and last rows separate fill substitution from wrap-around, and they also test the carry registers between adjacent blocks.

// File: rtl/fbw_pkg.sv
`timescale 1ns/1ps
package fbw_pkg;

  // Strobes and tuple position from the controller to the datapath
  typedef struct packed {
    logic step;      // queues and window registers advance this cycle
    logic flush;     // synthetic step after the last input block
    logic tupValid;  // tuple centre row lies inside the image
    logic tupTop;    // tuple centre is image row 0
    logic tupBot;    // tuple centre is the last image row
    logic tupFirst;  // tuple is column block 0
    logic tupLast;   // tuple is the last column block
  } fbwCtl_t;

endpackage

// File: rtl/fbw_line_queue.sv
`timescale 1ns/1ps
module fbw_line_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;

  // Oldest entry is read at the slot about to be overwritten
  assign dout = mem[ptr];

  always_ff @(posedge clk) begin
    if (push) mem[ptr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ptr <= '0;
    else if (push) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/fbw_ctrl.sv
`timescale 1ns/1ps
module fbw_ctrl
  import fbw_pkg::*;
#(
  parameter int HEIGHT = 6,
  parameter int BLK    = 4,
  parameter int LAG    = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output fbwCtl_t ctl
);
  localparam int ROWEND = HEIGHT + LAG;
  localparam int RW = $clog2(ROWEND + 1) + 1;
  localparam int CW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [RW-1:0] ROW_LAST  = RW'(HEIGHT - 1);
  localparam logic [RW-1:0] ROW_END   = RW'(ROWEND);
  localparam logic [RW-1:0] ROW_FIRST = RW'(LAG);
  localparam logic [RW-1:0] ROW_BOT   = RW'(ROWEND - 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(BLK - 1);

  logic [CW-1:0] inCol;
  logic [RW-1:0] inRow;
  logic          flushing;
  logic          step;

  assign inReady = !flushing;
  assign step    = flushing || inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCol    <= '0;
      inRow    <= '0;
      flushing <= 1'b0;
    end else if (step) begin
      if (flushing && inRow == ROW_END) begin
        flushing <= 1'b0;
        inRow    <= '0;
        inCol    <= '0;
      end else begin
        if (inCol == COL_LAST) begin
          inCol <= '0;
          inRow <= inRow + 1'b1;
        end else begin
          inCol <= inCol + 1'b1;
        end
        if (!flushing && inRow == ROW_LAST && inCol == COL_LAST) flushing <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl.step     = step;
    ctl.flush    = flushing;
    ctl.tupValid = (inRow >= ROW_FIRST) && (inRow < ROW_END);
    ctl.tupTop   = (inRow == ROW_FIRST);
    ctl.tupBot   = (inRow == ROW_BOT);
    ctl.tupFirst = (inCol == '0);
    ctl.tupLast  = (inCol == COL_LAST);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(inCol) && $stable(inRow));  // R7

  AST_FLUSH_END: assert property (@(posedge clk) disable iff (!rstN)
    (flushing && inRow == ROW_END) |=> (inReady && inRow == '0 && inCol == '0));  // R8

endmodule

// File: rtl/fbw_datapath.sv
`timescale 1ns/1ps
module fbw_datapath
  import fbw_pkg::*;
#(
  parameter int          WIDTH     = 16,
  parameter int          DW        = 8,
  parameter int          P         = 4,
  parameter bit          WRAP_MODE = 1'b0,
  parameter logic [DW-1:0] FILL    = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbwCtl_t           ctl,
  input  logic [P*DW-1:0]   inPix,
  output logic              outValid,
  output logic [P*9*DW-1:0] outWin,
  output logic [P-1:0]      outBorder
);
  localparam int BLK = WIDTH / P;
  localparam int BW  = P * DW;
  localparam int NQ  = WRAP_MODE ? 3 : 2;

  logic [BW-1:0] qIn;
  logic [BW-1:0] qOut [NQ];
  logic [BW-1:0] inSide [3];
  logic [BW-1:0] tup [3];
  logic [DW-1:0] leftSub [3];
  logic [DW-1:0] rightSub [3];

  assign qIn = ctl.flush ? {P{FILL}} : inPix;

  // Row queues, each one image row of blocks deep
  for (genvar q = 0; q < NQ; q++) begin : g_queue
    if (q == 0) begin : g_head
      fbw_line_queue #(.DEPTH(BLK), .W(BW)) queue_i (
        .clk(clk), .rstN(rstN), .push(ctl.step), .din(qIn), .dout(qOut[q]));
    end else begin : g_chain
      fbw_line_queue #(.DEPTH(BLK), .W(BW)) queue_i (
        .clk(clk), .rstN(rstN), .push(ctl.step), .din(qOut[q-1]), .dout(qOut[q]));
    end
  end

  // Index 0 = top window row
  assign inSide[0] = qOut[1];
  assign inSide[1] = qOut[0];
  assign inSide[2] = qIn;

  if (WRAP_MODE) begin : g_wrap
    assign tup[0] = qOut[2];
    assign tup[1] = qOut[1];
    assign tup[2] = qOut[0];
    // Last column seen on the input side, first column seen on the tuple side
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < 3; r++) begin
          leftSub[r]  <= FILL;
          rightSub[r] <= FILL;
        end
      end else if (ctl.step) begin
        for (int r = 0; r < 3; r++) begin
          if (ctl.tupLast)  leftSub[r]  <= inSide[r][BW-1 -: DW];
          if (ctl.tupFirst) rightSub[r] <= tup[r][DW-1:0];
        end
      end
    end
  end else begin : g_const
    assign tup[0] = inSide[0];
    assign tup[1] = inSide[1];
    assign tup[2] = inSide[2];
    always_comb begin
      for (int r = 0; r < 3; r++) begin
        leftSub[r]  = FILL;
        rightSub[r] = FILL;
      end
    end
  end

  logic [BW-1:0] cur [3];
  logic [DW-1:0] carry [3];
  logic          curValid, curTop, curBot, curFirst, curLast;
  logic [DW-1:0] ext [3][P+2];
  logic [P*9*DW-1:0] nextWin;
  logic [P-1:0]      nextBorder;

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      ext[r][0]   = curFirst ? leftSub[r] : carry[r];
      ext[r][P+1] = curLast ? rightSub[r] : tup[r][DW-1:0];
      for (int k = 0; k < P; k++) ext[r][k+1] = cur[r][k*DW +: DW];
      if ((r == 0 && curTop) || (r == 2 && curBot)) begin
        for (int k = 0; k < P + 2; k++) ext[r][k] = FILL;
      end
    end
    for (int j = 0; j < P; j++) begin
      for (int r = 0; r < 3; r++) begin
        for (int c = 0; c < 3; c++) begin
          nextWin[(j*9 + r*3 + c)*DW +: DW] = ext[r][j+c];
        end
      end
      nextBorder[j] = curTop || curBot || (curFirst && j == 0) || (curLast && j == P-1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < 3; r++) begin
        cur[r]   <= '0;
        carry[r] <= '0;
      end
      curValid  <= 1'b0;
      curTop    <= 1'b0;
      curBot    <= 1'b0;
      curFirst  <= 1'b0;
      curLast   <= 1'b0;
      outValid  <= 1'b0;
      outWin    <= '0;
      outBorder <= '0;
    end else if (ctl.step) begin
      for (int r = 0; r < 3; r++) begin
        cur[r]   <= tup[r];
        carry[r] <= cur[r][BW-1 -: DW];
      end
      curValid <= ctl.tupValid;
      curTop   <= ctl.tupTop;
      curBot   <= ctl.tupBot;
      curFirst <= ctl.tupFirst;
      curLast  <= ctl.tupLast;
      outValid <= curValid;
      if (curValid) begin
        outWin    <= nextWin;
        outBorder <= nextBorder;
      end
    end else begin
      outValid <= 1'b0;
    end
  end

  AST_EMIT_AFTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(ctl.step));  // R2

  AST_FIRST_COL_BORDER: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && curValid && curFirst) |=> (outValid && outBorder[0]));  // R6

endmodule

// File: rtl/fbw_pe_centre.sv
`timescale 1ns/1ps
module fbw_pe_centre #(
  parameter int DW = 8,
  parameter int P  = 4
) (
  input  logic [P*9*DW-1:0] win,
  output logic [P*DW-1:0]   result
);
  for (genvar j = 0; j < P; j++) begin : g_pe
    assign result[j*DW +: DW] = win[(j*9 + 4)*DW +: DW];
  end
endmodule

// File: rtl/par_window_gen.sv
`timescale 1ns/1ps
module par_window_gen
  import fbw_pkg::*;
#(
  parameter int            WIDTH     = 16,
  parameter int            HEIGHT    = 6,
  parameter int            DW        = 8,
  parameter int            P         = 4,
  parameter bit            WRAP_MODE = 1'b0,
  parameter logic [DW-1:0] FILL      = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [P*DW-1:0]   inPix,
  output logic              outValid,
  output logic [P*9*DW-1:0] outWin,
  output logic [P-1:0]      outBorder,
  output logic [P*DW-1:0]   outPix
);
  localparam int BLK = WIDTH / P;
  localparam int LAG = WRAP_MODE ? 2 : 1;

  fbwCtl_t ctl;

  fbw_ctrl #(.HEIGHT(HEIGHT), .BLK(BLK), .LAG(LAG)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .ctl(ctl));

  fbw_datapath #(.WIDTH(WIDTH), .DW(DW), .P(P), .WRAP_MODE(WRAP_MODE), .FILL(FILL)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inPix(inPix),
    .outValid(outValid), .outWin(outWin), .outBorder(outBorder));

  fbw_pe_centre #(.DW(DW), .P(P)) pe_i (.win(outWin), .result(outPix));

endmodule

// File: tb/par_window_gen_tb_top.sv
`timescale 1ns/1ps
module par_window_gen_tb_top;
  localparam int AW = 16, AH = 5, AP = 4;
  localparam int BWD = 8, BH = 4, BP = 2;
  localparam logic [7:0] AFILL = 8'hA5;
  localparam logic [7:0] BFILL = 8'hF0;
  localparam int FRAMES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        inValidA = 1'b0, inReadyA, outValidA;
  logic [31:0] inPixA = '0, outPixA;
  logic [287:0] outWinA;
  logic [3:0]  outBorderA;
  logic        inValidB = 1'b0, inReadyB, outValidB;
  logic [15:0] inPixB = '0, outPixB;
  logic [143:0] outWinB;
  logic [1:0]  outBorderB;

  par_window_gen #(.WIDTH(AW), .HEIGHT(AH), .DW(8), .P(AP), .WRAP_MODE(1'b0), .FILL(AFILL)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValidA), .inReady(inReadyA), .inPix(inPixA),
    .outValid(outValidA), .outWin(outWinA), .outBorder(outBorderA), .outPix(outPixA));

  par_window_gen #(.WIDTH(BWD), .HEIGHT(BH), .DW(8), .P(BP), .WRAP_MODE(1'b1), .FILL(BFILL)) dutWrap_i (
    .clk(clk), .rstN(rstN), .inValid(inValidB), .inReady(inReadyB), .inPix(inPixB),
    .outValid(outValidB), .outWin(outWinB), .outBorder(outBorderB), .outPix(outPixB));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int eRow[2], eBlk[2], eFrm[2], outCnt[2], accCyc[2];
  bit seenAcc[2], seenOut[2];
  logic vA, rA, vB, rB;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pixVal(int f, int r, int c);
    return 8'(r*16 + c + 1 + f*50);
  endfunction

  function automatic logic [7:0] expPix(int f, int rr, int cc, int w, int h, bit wrap, logic [7:0] fill);
    int col = cc;
    if (rr < 0 || rr >= h) return fill;
    if (col < 0) begin
      if (!wrap) return fill;
      col = col + w;
    end else if (col >= w) begin
      if (!wrap) return fill;
      col = col - w;
    end
    return pixVal(f, rr, col);
  endfunction

  task automatic mon(input int id, input bit acc, input bit stepped, input bit ov,
                     input logic [287:0] win, input logic [31:0] pv, input logic [3:0] bd);
    int p = (id == 0) ? AP : BP;
    int w = (id == 0) ? AW : BWD;
    int h = (id == 0) ? AH : BH;
    int lag = (id == 0) ? 1 : 2;
    bit wrap = (id == 1);
    logic [7:0] fill = (id == 0) ? AFILL : BFILL;
    string winReq = (id == 0) ? "R1 R4 window" : "R1 R5 window";
    if (acc && !seenAcc[id]) begin
      seenAcc[id] = 1'b1;
      accCyc[id] = cyc;
    end
    if (!stepped) chk(ov == 1'b0, "R7 no output after idle edge", int'(ov), 0);
    if (ov) begin
      if (!seenOut[id]) begin
        seenOut[id] = 1'b1;
        chk(cyc - accCyc[id] == lag*(w/p) + 1, "R3 fill latency", cyc - accCyc[id], lag*(w/p) + 1);
      end
      for (int j = 0; j < p; j++) begin
        bit okW = 1'b1;
        int actV = 0, expV = 0;
        int col = eBlk[id]*p + j;
        bit eb;
        logic [7:0] ctr;
        for (int r = 0; r < 3; r++) begin
          for (int c = 0; c < 3; c++) begin
            logic [7:0] e = expPix(eFrm[id], eRow[id] + r - 1, col + c - 1, w, h, wrap, fill);
            logic [7:0] a = win[(j*9 + r*3 + c)*8 +: 8];
            if (okW && a != e) begin
              okW = 1'b0;
              actV = int'(a);
              expV = int'(e);
            end
          end
        end
        chk(okW, winReq, actV, expV);
        eb = (eRow[id] == 0) || (eRow[id] == h-1) || (col == 0) || (col == w-1);
        chk(bd[j] == eb, "R6 border flag", int'(bd[j]), int'(eb));
        ctr = pixVal(eFrm[id], eRow[id], col);
        chk(pv[j*8 +: 8] == ctr, "R9 centre pass-through", int'(pv[j*8 +: 8]), int'(ctr));
      end
      outCnt[id]++;
      eBlk[id]++;
      if (eBlk[id] == w/p) begin
        eBlk[id] = 0;
        eRow[id]++;
        if (eRow[id] == h) begin
          eRow[id] = 0;
          eFrm[id]++;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    vA <= inValidA; rA <= inReadyA;
    vB <= inValidB; rB <= inReadyB;
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      mon(0, vA && rA, (vA && rA) || !rA, outValidA, outWinA, outPixA, outBorderA);
      mon(1, vB && rB, (vB && rB) || !rB, outValidB, {144'd0, outWinB}, {16'd0, outPixB}, {2'd0, outBorderB});
    end
  end

  task automatic driveFrames(input int id);
    int p = (id == 0) ? AP : BP;
    int w = (id == 0) ? AW : BWD;
    int h = (id == 0) ? AH : BH;
    int lag = (id == 0) ? 1 : 2;
    for (int f = 0; f < FRAMES; f++) begin
      int lowCnt = 0;
      for (int r = 0; r < h; r++) begin
        for (int b = 0; b < w/p; b++) begin
          bit accepted = 1'b0;
          bit gap = (f == 1) && (b % 3 == 1);
          while (!accepted) begin
            logic [31:0] data = '0;
            bit rdy;
            @(negedge clk); #1;
            for (int j = 0; j < p; j++) data[j*8 +: 8] = pixVal(f, r, b*p + j);
            if (id == 0) begin
              inValidA = !gap; inPixA = data; rdy = inReadyA;
            end else begin
              inValidB = !gap; inPixB = data[15:0]; rdy = inReadyB;
            end
            @(posedge clk);
            accepted = !gap && rdy;
            gap = 1'b0;
          end
        end
      end
      // Flush window: ready must stay low for the drain steps
      while (1) begin
        bit rdy;
        @(negedge clk); #1;
        if (id == 0) begin inValidA = 1'b0; rdy = inReadyA; end
        else begin inValidB = 1'b0; rdy = inReadyB; end
        if (rdy) break;
        lowCnt++;
      end
      chk(lowCnt == lag*(w/p) + 1, "R8 flush length", lowCnt, lag*(w/p) + 1);
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      eRow[i] = 0; eBlk[i] = 0; eFrm[i] = 0; outCnt[i] = 0; accCyc[i] = 0;
      seenAcc[i] = 1'b0; seenOut[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(outValidA == 1'b0 && outValidB == 1'b0, "R2 reset outValid", int'(outValidA | outValidB), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReadyA && inReadyB, "R8 ready after reset", int'(inReadyA & inReadyB), 1);
    chk(outValidA == 1'b0, "R2 idle after reset", int'(outValidA), 0);
    fork
      driveFrames(0);
      driveFrames(1);
    join
    repeat (5) @(negedge clk);
    chk(outCnt[0] == FRAMES*AH*(AW/AP), "R2 output count constant", outCnt[0], FRAMES*AH*(AW/AP));
    chk(outCnt[1] == FRAMES*BH*(BWD/BP), "R2 output count torus", outCnt[1], FRAMES*BH*(BWD/BP));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule